// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Byte-Lane Writes

This block is a synthesizable model of a single-clock synchronous static RAM with 32-bit words. The address, write data and all controls are captured on the rising clock edge. The captured address reaches the storage array in the next cycle, and read data then passes through an output register. A write can update any mix of the four 8-bit lanes, or all four lanes together through a global write control. An output enable forces the data outputs to zero without waiting for a clock edge.

Three chip enables must all be in their active state for a cycle to be accepted. They are active-low, active-high and active-low. A sleep input puts the memory into power-down. While the memory is down, and for a fixed number of wake-up cycles after sleep falls, every access is dropped. The stored contents are kept. Burst address sequencing is outside this block, so the caller supplies every address. The depth is `2**ADDR_W` words. The default `ADDR_W` of 10 keeps elaboration small, and `ADDR_W = 16` gives 65,536 words.

Top module: `sync_pipe_sram`

## Requirements
- R1: A read presented at rising edge k is visible on `dout` after rising edge k+2. This is two cycles after the address is registered: one cycle for the array access and one for the output register.
- R2: With `gw_n` low, all 32 bits of the addressed word are written, whatever `bwe_n` and `be_n` hold.
- R3: With `gw_n` high and `bwe_n` low, each low bit `be_n[i]` writes bits `8*i+7 : 8*i` of the word. Lanes whose `be_n` bit is high keep their old value.
- R4: A cycle that writes no lane is a read. This covers `gw_n` and `bwe_n` both high (whatever `be_n` holds) and `bwe_n` low with `be_n` equal to 4'hF.
- R5: A cycle is accepted only when `ce_a_n` is low, `ce_b` is high and `ce_c_n` is low. In any other cycle, writes leave the array unchanged and reads leave `dout` unchanged.
- R6: A cycle in which `sleep` is high is ignored, and the array contents survive power-down.
- R7: After `sleep` is sampled low following a high, the next `WAKE_CYC` (default 3) rising edges ignore all accesses. The edge after them accepts normally.
- R8: The output register changes only when a read completes. Writes, ignored cycles and idle cycles leave `dout` as it was.
- R9: `oe_n` high forces `dout` to zero at once, without a clock edge. `oe_n` low shows the output register.
- R10: A read presented in the cycle right after a write to the same word returns the newly written bytes.
- R11: After reset, `dout` is zero with `oe_n` low and the memory is awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep | input | 1 | High requests power-down |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Qualifies the per-lane enables, active low |
| be_n | input | 4 | Per-lane write enables, active low, bit i selects bits 8i+7:8i |
| addr | input | ADDR_W | Word address |
| din | input | 32 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | 32 | Read data, zero while `oe_n` is high |

## Verification
Two operations land on one clock edge. When a write is followed at once by a read of the same word, the write commits to the array on the same edge that registers the read address. The bench drives such back-to-back pairs with full-word and single-lane writes. It expects the merged word two cycles after the read is registered. The bench also raises sleep while an accepted read is still in the pipeline. The scoreboard requires that the read still delivers its data and that the accesses made during sleep and wake-up leave both the array and the output unchanged.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int LANE_W    = 8;
  localparam int NUM_LANES = 4;
  localparam int WORD_W    = LANE_W * NUM_LANES;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_DOWN = 2'd1,
    PWR_WAKE = 2'd2
  } pwr_state_e;

  typedef struct packed {
    logic                 vld;
    logic                 wr;
    logic [NUM_LANES-1:0] lane_we;
  } req_t;
endpackage

// File: rtl/sps_rst_sync.sv
module sps_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/sps_pwr_ctl.sv
module sps_pwr_ctl
  import sps_pkg::*;
#(
  parameter int WAKE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  output logic awake
);
  localparam int CNT_W = $clog2(WAKE_CYC + 1);

  pwr_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // next-state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (sleep) begin
      state_d = PWR_DOWN;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        PWR_DOWN: begin
          if (WAKE_CYC <= 1) begin
            state_d = PWR_RUN;
          end else begin
            state_d = PWR_WAKE;
            cnt_d   = CNT_W'(WAKE_CYC - 1);
          end
        end
        PWR_WAKE: begin
          if (cnt_q <= CNT_W'(1)) state_d = PWR_RUN;
          else                    cnt_d   = cnt_q - CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PWR_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign awake = (state_q == PWR_RUN) && !sleep;
endmodule

// File: rtl/sps_wr_qual.sv
module sps_wr_qual
  import sps_pkg::*;
(
  input  logic                 ce_a_n,
  input  logic                 ce_b,
  input  logic                 ce_c_n,
  input  logic                 awake,
  input  logic                 gw_n,
  input  logic                 bwe_n,
  input  logic [NUM_LANES-1:0] be_n,
  output req_t                 req
);
  logic                 sel;
  logic [NUM_LANES-1:0] lanes;

  always_comb begin
    sel = !ce_a_n && ce_b && !ce_c_n && awake;
    if (!gw_n)       lanes = '1;
    else if (!bwe_n) lanes = ~be_n;
    else             lanes = '0;
    req.vld     = sel;
    req.wr      = sel && (|lanes);
    req.lane_we = sel ? lanes : '0;
  end
endmodule

// File: rtl/sps_byte_array.sv
module sps_byte_array
  import sps_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                 clk,
  input  logic [NUM_LANES-1:0] wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_W-1:0]    wdata,
  output logic [WORD_W-1:0]    rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_en[g]) mem_q[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_en)    rd_q        <= mem_q[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sync_pipe_sram.sv
module sync_pipe_sram
  import sps_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int WAKE_CYC = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sleep,
  input  logic                 ce_a_n,
  input  logic                 ce_b,
  input  logic                 ce_c_n,
  input  logic                 gw_n,
  input  logic                 bwe_n,
  input  logic [NUM_LANES-1:0] be_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_W-1:0]    din,
  input  logic                 oe_n,
  output logic [WORD_W-1:0]    dout
);
  logic              rst_n_s;
  logic              awake;
  req_t              req_d, a_req_q;
  logic [ADDR_W-1:0] a_addr_q;
  logic [WORD_W-1:0] a_din_q;
  logic              a_vld;
  logic              arr_rd_en;
  logic [WORD_W-1:0] arr_rdata;
  logic              b_rd_vld_q;
  logic [WORD_W-1:0] q_q, q_d;

  sps_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  sps_pwr_ctl #(.WAKE_CYC(WAKE_CYC)) u_pwr (
    .clk   (clk),
    .rst_n (rst_n_s),
    .sleep (sleep),
    .awake (awake)
  );

  sps_wr_qual u_qual (
    .ce_a_n (ce_a_n),
    .ce_b   (ce_b),
    .ce_c_n (ce_c_n),
    .awake  (awake),
    .gw_n   (gw_n),
    .bwe_n  (bwe_n),
    .be_n   (be_n),
    .req    (req_d)
  );

  // input capture stage
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) a_req_q <= '0;
    else          a_req_q <= req_d;
  end

  always_ff @(posedge clk) begin
    if (req_d.vld) begin
      a_addr_q <= addr;
      a_din_q  <= din;
    end
  end

  assign a_vld     = a_req_q.vld;
  assign arr_rd_en = a_req_q.vld && !a_req_q.wr;

  sps_byte_array #(.ADDR_W(ADDR_W)) u_array (
    .clk   (clk),
    .wr_en (a_req_q.lane_we),
    .rd_en (arr_rd_en),
    .addr  (a_addr_q),
    .wdata (a_din_q),
    .rdata (arr_rdata)
  );

  // output register stage
  always_comb begin
    q_d = q_q;
    if (b_rd_vld_q) q_d = arr_rdata;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      b_rd_vld_q <= 1'b0;
      q_q        <= '0;
    end else begin
      b_rd_vld_q <= arr_rd_en;
      q_q        <= q_d;
    end
  end

  assign dout = oe_n ? '0 : q_q;
endmodule

// File: rtl/sync_pipe_sram_chk.sv
module sync_pipe_sram_chk
  import sps_pkg::*;
#(
  parameter int WAKE_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              ce_a_n,
  input logic              ce_b,
  input logic              ce_c_n,
  input logic              a_vld,
  input logic              a_rd,
  input logic              b_rd_vld,
  input logic [WORD_W-1:0] q
);
  localparam int LC_W = $clog2(WAKE_CYC + 1) + 1;

  logic [LC_W-1:0] low_cnt;

  // edges with sleep low since the last high, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          low_cnt <= LC_W'(WAKE_CYC);
    else if (sleep)                      low_cnt <= '0;
    else if (low_cnt < LC_W'(WAKE_CYC))  low_cnt <= low_cnt + LC_W'(1);
  end

  p_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    a_rd |=> b_rd_vld);

  p_ce_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_a_n || !ce_b || ce_c_n) |=> !a_vld);

  p_sleep_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !a_vld);

  p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    a_vld |-> ($past(low_cnt) >= LC_W'(WAKE_CYC)));

  p_q_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !b_rd_vld |=> $stable(q));
endmodule

bind sync_pipe_sram sync_pipe_sram_chk #(.WAKE_CYC(WAKE_CYC)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .sleep    (sleep),
  .ce_a_n   (ce_a_n),
  .ce_b     (ce_b),
  .ce_c_n   (ce_c_n),
  .a_vld    (a_vld),
  .a_rd     (arr_rd_en),
  .b_rd_vld (b_rd_vld_q),
  .q        (q_q)
);

// File: tb/sync_pipe_sram_tb_top.sv
module sync_pipe_sram_tb_top;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep = 1'b0;
  logic          ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
  logic          gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0]    be_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [31:0]   din = '0;
  logic          oe_n = 1'b0;
  logic [31:0]   dout;

  sync_pipe_sram #(.ADDR_W(AW), .WAKE_CYC(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep(sleep),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .be_n(be_n),
    .addr(addr), .din(din), .oe_n(oe_n), .dout(dout)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    int          due;
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  logic [31:0] shadow [int];
  logic [31:0] model_q = '0;
  int          low_cnt = 3;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares dout with scoreboard items as they come due
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      if (sb_q[0].due < cyc) begin
        n_checks++; n_fail++;
        $display("FAIL %s actual=missed expected=%h", sb_q[0].tag, sb_q[0].exp);
      end else begin
        chk(sb_q[0].tag, dout, sb_q[0].exp);
      end
      void'(sb_q.pop_front());
    end
  end

  // driver: one cycle of stimulus, updates the reference model
  task automatic op(input logic [2:0] en, input logic gw_i, input logic bwe_i,
                    input logic [3:0] be_i, input logic [AW-1:0] a,
                    input logic [31:0] d, input logic slp, input string tag);
    logic [3:0]  lanes;
    logic [31:0] w;
    bit          acc;
    exp_t        e;
    @(negedge clk); #1;
    ce_a_n = !en[0]; ce_b = en[1]; ce_c_n = !en[2];
    gw_n = gw_i; bwe_n = bwe_i; be_n = be_i; addr = a; din = d; sleep = slp;
    lanes = !gw_i ? 4'hF : (!bwe_i ? ~be_i : 4'h0);
    acc = (&en) && !slp && (low_cnt >= 3);
    if (slp) low_cnt = 0; else if (low_cnt < 3) low_cnt++;
    if (lanes != 4'h0) begin
      if (acc) begin
        w = shadow.exists(int'(a)) ? shadow[int'(a)] : 32'h0;
        for (int l = 0; l < 4; l++) if (lanes[l]) w[l*8 +: 8] = d[l*8 +: 8];
        shadow[int'(a)] = w;
      end
    end else begin
      if (acc) model_q = shadow[int'(a)];
      e.due = cyc + 3; e.exp = model_q; e.tag = tag;
      sb_q.push_back(e);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    op(3'b111, 1'b0, 1'b1, 4'hF, a, d, 1'b0, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    op(3'b111, 1'b1, 1'b1, 4'hF, a, 32'h0, 1'b0, tag);
  endtask

  task automatic idle(input logic slp);
    @(negedge clk); #1;
    ce_a_n = 1'b1; ce_b = 1'b0; ce_c_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1;
    be_n = 4'hF; sleep = slp;
    if (slp) low_cnt = 0; else if (low_cnt < 3) low_cnt++;
  endtask

  initial begin
    #(8 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) idle(1'b0);
    chk("R11 reset output", dout, 32'h0);

    // R2: global write overrides lane controls
    op(3'b111, 1'b0, 1'b1, 4'hF, 10'h000, 32'h1122_3344, 1'b0, "R2 wr");
    op(3'b111, 1'b0, 1'b0, 4'hF, 10'h002, 32'hDEAD_BEEF, 1'b0, "R2 wr");
    rd(10'h000, "R2 R1 read all lanes");
    rd(10'h002, "R2 read gw with bwe");

    // R3: per-lane writes
    wr(10'h001, 32'hAAAA_AAAA, "R3 base");
    op(3'b111, 1'b1, 1'b0, 4'b1110, 10'h001, 32'h0000_00BB, 1'b0, "R3 lane0");
    op(3'b111, 1'b1, 1'b0, 4'b0111, 10'h001, 32'hCC00_0000, 1'b0, "R3 lane3");
    op(3'b111, 1'b1, 1'b0, 4'b1001, 10'h001, 32'h0055_6600, 1'b0, "R3 lanes12");
    rd(10'h001, "R3 merged lanes");

    // R4: no lane selected means read
    op(3'b111, 1'b1, 1'b1, 4'h0, 10'h001, 32'h0, 1'b0, "R4 bwe high read");
    op(3'b111, 1'b1, 1'b0, 4'hF, 10'h000, 32'h0, 1'b0, "R4 no lanes read");

    // R5: each chip enable inactive
    op(3'b110, 1'b0, 1'b1, 4'hF, 10'h000, 32'h0BAD_0001, 1'b0, "R5 ce_a");
    op(3'b101, 1'b0, 1'b1, 4'hF, 10'h000, 32'h0BAD_0002, 1'b0, "R5 ce_b");
    op(3'b011, 1'b0, 1'b1, 4'hF, 10'h000, 32'h0BAD_0003, 1'b0, "R5 ce_c");
    op(3'b011, 1'b1, 1'b1, 4'hF, 10'h001, 32'h0, 1'b0, "R5 R8 ignored read holds");
    rd(10'h000, "R5 word unchanged");

    // R10: read right after write
    wr(10'h3FF, 32'h0F0F_F0F0, "R10 wr top");
    rd(10'h3FF, "R10 raw full word");
    op(3'b111, 1'b1, 1'b0, 4'b1101, 10'h3FF, 32'h0000_7700, 1'b0, "R10 lane1");
    rd(10'h3FF, "R10 raw lane write");
    wr(10'h004, 32'h0000_0005, "R6 pre");
    repeat (4) idle(1'b0);

    // R8: idle and write cycles keep dout
    chk("R8 hold after idle", dout, model_q);

    // R6/R7: sleep, wake window, retention
    rd(10'h001, "R6 read before sleep");
    op(3'b111, 1'b0, 1'b1, 4'hF, 10'h004, 32'h6666_6666, 1'b1, "R6 sleep wr");
    op(3'b111, 1'b1, 1'b1, 4'hF, 10'h000, 32'h0, 1'b1, "R6 sleep read");
    idle(1'b1);
    op(3'b111, 1'b0, 1'b1, 4'hF, 10'h004, 32'h7777_0001, 1'b0, "R7 wake1");
    op(3'b111, 1'b1, 1'b1, 4'hF, 10'h000, 32'h0, 1'b0, "R7 wake2 read");
    op(3'b111, 1'b0, 1'b1, 4'hF, 10'h004, 32'h7777_0003, 1'b0, "R7 wake3");
    rd(10'h004, "R7 first accepted");
    rd(10'h000, "R6 retained");
    wr(10'h004, 32'h8888_0004, "R7 wr");
    rd(10'h004, "R7 wr after wake");
    repeat (4) idle(1'b0);

    // R9: asynchronous output enable
    @(posedge clk); #2;
    oe_n = 1'b1; #1;
    chk("R9 oe high", dout, 32'h0);
    oe_n = 1'b0; #1;
    chk("R9 oe low", dout, model_q);

    // R1: streaming reads
    rd(10'h002, "R1 stream a");
    rd(10'h3FF, "R1 stream b");
    rd(10'h001, "R1 stream c");
    repeat (5) idle(1'b0);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    end
    $finish;
  end
endmodule